// File: doc/BRIEF.md
# Power-Up Configuration Download Sequencer

This block brings a supervisory device from an unpowered state to a configured state. Two comparator flags drive it: one says the supply is above about 1 V, the other says it is above the 2.5 V undervoltage lockout. With neither flag set, the programmable output pins are released to high impedance. Once the supply passes 1 V, the pins are forced low. At lockout the block copies every word of the nonvolatile configuration region into the volatile configuration latches, in ascending order. The pins then follow their programmed logic.

During the whole power-up path the block holds a busy flag, and the bus controller uses it to refuse every transfer. A reboot request from the bus controller starts the copy again. A cycle budget bounds the copy: when the budget runs out, the block raises an error flag, releases busy and forces the pins low. The block reads the storage through a synchronous port whose data arrives one cycle after the read strobe, and a ready input lets the storage stall it.

States: OFF (no supply, pins high impedance, busy), HOLD (above 1 V and below lockout, pins low, busy), LOAD (copying, pins programmed, busy), RUN (configured, pins programmed), FAULT (budget exceeded, pins low, error). Transitions: loss of the 1 V flag goes to OFF from any state. Loss of lockout goes from LOAD, RUN or FAULT to HOLD. OFF goes to HOLD on the 1 V flag. HOLD goes to LOAD on lockout. LOAD goes to RUN after the last word is written, or to FAULT when the budget expires. RUN and FAULT go to LOAD on a reboot request.

Top module: `cfg_boot_seq`

## Requirements
- R1: After reset, out_mode is 2'b00 (high impedance), busy is 1, boot_err is 0 and no latch write occurs.
- R2: Whenever sup_above_1v is low, out_mode is 2'b00 one cycle later, whatever the state.
- R3: With sup_above_1v high and sup_above_uvlo low, out_mode is 2'b01 (driven low) one cycle later, and busy stays 1.
- R4: When sup_above_uvlo rises, the block reads storage addresses BASE_ADDR to BASE_ADDR+NUM_WORDS-1 in ascending order. The word returned for address BASE_ADDR+i is written to latch index i, in the cycle after its read.
- R5: out_mode is 2'b10 (programmed) during the copy and after it completes, and only while lockout held on the previous cycle.
- R6: busy stays 1 until the last word is written and falls on the next cycle. No latch write occurs while busy is 0.
- R7: No read is issued in a cycle where mem_ready is low, so a stalled storage delays the copy without losing words.
- R8: If the copy has not finished TIMEOUT_CYC cycles after it starts, boot_err becomes 1, busy falls to 0 and out_mode becomes 2'b01.
- R9: A reboot_req pulse in RUN or FAULT makes busy 1 on the next cycle, clears boot_err and repeats the full copy from index 0.
- R10: If sup_above_uvlo falls during the copy, the copy stops with no further latch write, out_mode becomes 2'b01 with busy 1, and the next lockout starts over from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_above_1v | input | 1 | Supply above about 1 V, synchronized comparator flag |
| sup_above_uvlo | input | 1 | Supply above lockout threshold, synchronized comparator flag |
| reboot_req | input | 1 | One-cycle request from the bus controller to restart the download |
| mem_ready | input | 1 | Storage can accept a read this cycle |
| mem_rd_en | output | 1 | Read strobe to the storage |
| mem_addr | output | ADDR_W | Storage read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after mem_rd_en |
| cfg_wr_en | output | 1 | Latch write strobe |
| cfg_wr_idx | output | IDX_W | Latch index written |
| cfg_wr_data | output | DATA_W | Latch write data |
| out_mode | output | 2 | Pin control: 00 high impedance, 01 low, 10 programmed |
| busy | output | 1 | Bus controller must NACK all traffic |
| boot_err | output | 1 | Download exceeded its cycle budget |

## Verification
The copy runs with the storage always ready and then with the ready line toggling. Matching results separate a correct stall from a dropped or repeated word. Each run uses a different data seed, so a repeat after a reboot is distinguishable from stale latch contents. A run is aborted mid-copy by dropping lockout and then restarted, which shows that the index returns to zero. A run with the storage never ready exercises the cycle budget, and the timeout edge is sampled on the exact cycle on each side of it.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_LOAD,
        ST_RUN,
        ST_FAULT
    } boot_state_t;

    typedef enum logic [1:0] {
        PIN_HIZ  = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_PROG = 2'b10
    } pin_mode_t;

endpackage

// File: rtl/cfg_boot_timer.sv
module cfg_boot_timer #(
    parameter int TIMEOUT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt;

    assign expired = run_en && (cnt == TW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run_en)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_boot_copier.sv
module cfg_boot_copier #(
    parameter int NUM_WORDS = 32,
    parameter int BASE_ADDR = 128,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int CW       = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              mem_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              cfg_wr_en,
    output logic [IDX_W-1:0]  cfg_wr_idx,
    output logic [DATA_W-1:0] cfg_wr_data,
    output logic              done
);
    logic [CW-1:0]    rd_idx;
    logic             pend;
    logic [IDX_W-1:0] pend_idx;

    assign mem_rd_en   = active && mem_ready && (rd_idx < CW'(NUM_WORDS));
    assign mem_addr    = ADDR_W'(BASE_ADDR) + ADDR_W'(rd_idx);
    assign cfg_wr_en   = pend && active;
    assign cfg_wr_idx  = pend_idx;
    assign cfg_wr_data = mem_rd_data;
    assign done        = cfg_wr_en && (pend_idx == IDX_W'(NUM_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx   <= '0;
            pend     <= 1'b0;
            pend_idx <= '0;
        end else if (!active) begin
            rd_idx   <= '0;
            pend     <= 1'b0;
        end else begin
            pend <= mem_rd_en;
            if (mem_rd_en) begin
                rd_idx   <= rd_idx + 1'b1;
                pend_idx <= IDX_W'(rd_idx);
            end
        end
    end
endmodule

// File: rtl/cfg_boot_fsm.sv
module cfg_boot_fsm
    import cfg_boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sup_above_1v,
    input  logic        sup_above_uvlo,
    input  logic        reboot_req,
    input  logic        done,
    input  logic        expired,
    output boot_state_t state,
    output pin_mode_t   pin_mode,
    output logic        busy,
    output logic        boot_err
);
    boot_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  if (sup_above_1v) nxt = ST_HOLD;
            ST_HOLD: begin
                if (!sup_above_1v)       nxt = ST_OFF;
                else if (sup_above_uvlo) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (!sup_above_1v)        nxt = ST_OFF;
                else if (!sup_above_uvlo) nxt = ST_HOLD;
                else if (done)            nxt = ST_RUN;
                else if (expired)         nxt = ST_FAULT;
            end
            ST_RUN, ST_FAULT: begin
                if (!sup_above_1v)        nxt = ST_OFF;
                else if (!sup_above_uvlo) nxt = ST_HOLD;
                else if (reboot_req)      nxt = ST_LOAD;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        pin_mode = PIN_HIZ;
        busy     = 1'b1;
        boot_err = 1'b0;
        unique case (state)
            ST_OFF:   pin_mode = PIN_HIZ;
            ST_HOLD:  pin_mode = PIN_LOW;
            ST_LOAD:  pin_mode = PIN_PROG;
            ST_RUN: begin
                pin_mode = PIN_PROG;
                busy     = 1'b0;
            end
            ST_FAULT: begin
                pin_mode = PIN_LOW;
                busy     = 1'b0;
                boot_err = 1'b1;
            end
            default:  pin_mode = PIN_HIZ;
        endcase
    end
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cfg_boot_pkg::*;
#(
    parameter int NUM_WORDS   = 32,
    parameter int BASE_ADDR   = 128,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 200,
    localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_above_1v,
    input  logic              sup_above_uvlo,
    input  logic              reboot_req,
    input  logic              mem_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              cfg_wr_en,
    output logic [IDX_W-1:0]  cfg_wr_idx,
    output logic [DATA_W-1:0] cfg_wr_data,
    output logic [1:0]        out_mode,
    output logic              busy,
    output logic              boot_err
);
    boot_state_t state;
    pin_mode_t   pin_mode;
    logic        done;
    logic        expired;
    logic        loading;

    assign loading  = (state == ST_LOAD);
    assign out_mode = pin_mode;

    cfg_boot_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sup_above_1v   (sup_above_1v),
        .sup_above_uvlo (sup_above_uvlo),
        .reboot_req     (reboot_req),
        .done           (done),
        .expired        (expired),
        .state          (state),
        .pin_mode       (pin_mode),
        .busy           (busy),
        .boot_err       (boot_err)
    );

    cfg_boot_copier #(
        .NUM_WORDS (NUM_WORDS),
        .BASE_ADDR (BASE_ADDR),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_copier (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (loading),
        .mem_ready   (mem_ready),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_idx  (cfg_wr_idx),
        .cfg_wr_data (cfg_wr_data),
        .done        (done)
    );

    cfg_boot_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (loading),
        .expired (expired)
    );
endmodule

// File: rtl/cfg_boot_chk.sv
module cfg_boot_chk #(
    parameter int NUM_WORDS = 32,
    parameter int BASE_ADDR = 128,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sup_above_1v,
    input logic              sup_above_uvlo,
    input logic              mem_ready,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cfg_wr_en,
    input logic [1:0]        out_mode,
    input logic              busy,
    input logic              boot_err
);
    AST_HIZ_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_above_1v |=> out_mode == 2'b00); // R2

    AST_LOW_BELOW_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_above_1v && !sup_above_uvlo) |=> (out_mode == 2'b01 && busy)); // R3

    AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= ADDR_W'(BASE_ADDR) &&
                       mem_addr <= ADDR_W'(BASE_ADDR + NUM_WORDS - 1))); // R4

    AST_PROG_NEEDS_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b10) |-> $past(sup_above_uvlo)); // R5

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> busy); // R6

    AST_READ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_ready); // R7

    AST_ERR_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> (!busy && out_mode == 2'b01)); // R8
endmodule

bind cfg_boot_seq cfg_boot_chk #(
    .NUM_WORDS (NUM_WORDS),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sup_above_1v   (sup_above_1v),
    .sup_above_uvlo (sup_above_uvlo),
    .mem_ready      (mem_ready),
    .mem_rd_en      (mem_rd_en),
    .mem_addr       (mem_addr),
    .cfg_wr_en      (cfg_wr_en),
    .out_mode       (out_mode),
    .busy           (busy),
    .boot_err       (boot_err)
);

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW   = 32;
    localparam int BASE = 128;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int TO   = 200;
    localparam int IW   = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_above_1v = 1'b0;
    logic          sup_above_uvlo = 1'b0;
    logic          reboot_req = 1'b0;
    logic          mem_ready = 1'b1;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          cfg_wr_en;
    logic [IW-1:0] cfg_wr_idx;
    logic [DW-1:0] cfg_wr_data;
    logic [1:0]    out_mode;
    logic          busy;
    logic          boot_err;

    int            n_chk = 0;
    int            n_fail = 0;
    int            n_wr = 0;
    logic [DW-1:0] seed = 8'h00;
    logic          toggle_ready = 1'b0;
    int            exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_boot_seq #(
        .NUM_WORDS (NW), .BASE_ADDR (BASE), .ADDR_W (AW),
        .DATA_W (DW), .TIMEOUT_CYC (TO)
    ) u_cfg_boot_seq (
        .clk (clk), .rst_n (rst_n),
        .sup_above_1v (sup_above_1v), .sup_above_uvlo (sup_above_uvlo),
        .reboot_req (reboot_req), .mem_ready (mem_ready),
        .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rd_data (mem_rd_data),
        .cfg_wr_en (cfg_wr_en), .cfg_wr_idx (cfg_wr_idx), .cfg_wr_data (cfg_wr_data),
        .out_mode (out_mode), .busy (busy), .boot_err (boot_err)
    );

    function automatic logic [DW-1:0] word_of(input int addr, input logic [DW-1:0] s);
        return DW'(addr * 3) ^ s;
    endfunction

    // synchronous storage model: data one cycle after the read strobe
    always @(posedge clk)
        if (mem_rd_en) mem_rd_data <= word_of(int'(mem_addr), seed);

    always @(negedge clk)
        if (toggle_ready) mem_ready <= ~mem_ready;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: push the expected latch contents of a full download
    task automatic push_run(input logic [DW-1:0] s);
        seed = s;
        for (int i = 0; i < NW; i++)
            exp_q.push_back((i << 8) | int'(word_of(BASE + i, s)));
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    task automatic pulse_reboot();
        @(negedge clk) reboot_req = 1'b1;
        @(negedge clk) reboot_req = 1'b0;
    endtask

    // monitor: compare each latch write against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en && !mem_ready)
                chk(1'b0, "R7 read while not ready", 1, 0);
            if (cfg_wr_en) begin
                n_wr++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected latch write", int'(cfg_wr_idx), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(((int'(cfg_wr_idx) << 8) | int'(cfg_wr_data)) == e,
                        "R4 latch write idx/data", (int'(cfg_wr_idx) << 8) | int'(cfg_wr_data), e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_mode == 2'b00, "R1 out_mode after reset", out_mode, 0);
        chk(busy == 1'b1, "R1 busy after reset", busy, 1);
        chk(boot_err == 1'b0, "R1 err after reset", boot_err, 0);

        sup_above_1v = 1'b1;
        @(negedge clk);
        chk(out_mode == 2'b01, "R3 pins low above 1 V", out_mode, 1);
        chk(busy == 1'b1, "R3 busy below lockout", busy, 1);

        // full download, storage always ready
        push_run(8'h11);
        sup_above_uvlo = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(out_mode == 2'b10, "R5 programmed during copy", out_mode, 2);
        chk(busy == 1'b1, "R6 busy during copy", busy, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R6 all words before busy falls", exp_q.size(), 0);
        chk(busy == 1'b0 && boot_err == 1'b0, "R6 idle after copy", {busy, boot_err}, 0);
        repeat (5) @(negedge clk);
        chk(out_mode == 2'b10, "R5 programmed after copy", out_mode, 2);

        // reboot with a stalling storage
        push_run(8'hA7);
        toggle_ready = 1'b1;
        pulse_reboot();
        chk(busy == 1'b1, "R9 busy after reboot", busy, 1);
        wait_idle();
        toggle_ready = 1'b0;
        mem_ready = 1'b1;
        chk(exp_q.size() == 0, "R7 stalled copy complete", exp_q.size(), 0);

        // abort by lockout loss, then restart from index 0
        begin
            int start_wr;
            start_wr = n_wr;
            push_run(8'h3C);
            pulse_reboot();
            for (int k = 0; k < 200 && n_wr < start_wr + 10; k++) @(negedge clk);
            sup_above_uvlo = 1'b0;
            @(negedge clk);
            chk(out_mode == 2'b01, "R10 pins low after abort", out_mode, 1);
            chk(busy == 1'b1, "R10 busy after abort", busy, 1);
            exp_q.delete();
            repeat (4) @(negedge clk);
            push_run(8'hC5);
            sup_above_uvlo = 1'b1;
            @(negedge clk);
            wait_idle();
            chk(exp_q.size() == 0, "R10 restart from index 0", exp_q.size(), 0);
        end

        // timeout: storage never ready
        mem_ready = 1'b0;
        @(negedge clk) reboot_req = 1'b1;
        @(negedge clk) reboot_req = 1'b0;
        repeat (TO - 1) @(negedge clk);
        chk(boot_err == 1'b0, "R8 no error before budget", boot_err, 0);
        @(negedge clk);
        chk(boot_err == 1'b1, "R8 error at budget", boot_err, 1);
        chk(busy == 1'b0, "R8 busy released", busy, 0);
        chk(out_mode == 2'b01, "R8 pins low on fault", out_mode, 1);

        // reboot out of fault
        mem_ready = 1'b1;
        push_run(8'h5A);
        pulse_reboot();
        chk(boot_err == 1'b0, "R9 error cleared", boot_err, 0);
        wait_idle();
        chk(exp_q.size() == 0 && boot_err == 1'b0, "R9 copy after fault", exp_q.size(), 0);

        // supply removed
        sup_above_1v = 1'b0;
        sup_above_uvlo = 1'b0;
        @(negedge clk);
        chk(out_mode == 2'b00, "R2 high impedance without supply", out_mode, 0);
        chk(busy == 1'b1, "R2 busy without supply", busy, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule